// File: doc/BRIEF.md
# Dual-Channel Push-Button Reset Controller

This block turns two push-button style inputs into one timed reset request. The first channel watches an active-low long-press line. Only a closure held for a selectable setup time causes a reset, so a brief tap cannot reset the system. The second channel watches an active-high edge input. Its rising edge requests a reset at once. When the input falls after a reset it accepted, a long blanking window opens, and any new rising edge inside that window is ignored.

Both channels feed one reloadable pulse timer. The timer drives `rst_drive`, which is the enable for an external pull-down on the system reset line. All durations are counted in ticks. A tick is an enable that a prescaler produces every `TICK_DIV` clock cycles, so seconds-scale timing maps onto any clock. The requirements below state cycle counts for `TICK_DIV = 1`. With a larger divider each count is in ticks, and a one-tick uncertainty applies at the start.

Top module: `pbrst_ctrl`

## Requirements
- R1: `hold_sel` selects the setup time L: 2'b00 gives `HOLD_SHORT_TICKS`, 2'b01 gives `HOLD_MID_TICKS`, and 2'b10 or 2'b11 gives `HOLD_LONG_TICKS`. If `hold_n` is sampled low on L consecutive rising edges starting at edge k, `rst_drive` is high after edge k+L+1.
- R2: A closure sampled low on only L-1 consecutive edges leaves `rst_drive` low.
- R3: One continuous closure produces exactly one pulse, however long it is held. A new pulse needs a release first.
- R4: A rising edge on `edge_in` that is first sampled high at edge k, and that is not blanked, makes `rst_drive` high after edge k+2. No minimum high time is required.
- R5: A falling edge first sampled at edge f opens a blanking window of `DEBOUNCE_TICKS`, provided it ends a high phase whose rising edge was accepted. A rising edge first sampled at edge f+1 through f+`DEBOUNCE_TICKS` is ignored. The fall of an ignored high phase does not reopen the window.
- R6: A rising edge first sampled at edge f+`DEBOUNCE_TICKS`+1 or later is accepted.
- R7: A pulse keeps `rst_drive` high for P consecutive cycles. P is `PULSE_LONG_TICKS` when `PULSE_USE_LONG` is 1 and `PULSE_SHORT_TICKS` otherwise.
- R8: An accepted trigger from either channel during a running pulse reloads the timer. `rst_drive` then stays high until P cycles after the latest trigger.
- R9: `rst_drive` is low while `rst_n` is low, and it stays low after release until a trigger is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hold_n | input | 1 | Long-press button, active low, asynchronous |
| edge_in | input | 1 | Instant-reset button, active high, asynchronous |
| hold_sel | input | 2 | Setup-time select for the long-press channel |
| rst_drive | output | 1 | High to pull the system reset line low |

## Verification
A wrong hold count or a wrong select decode shifts the first high sample of `rst_drive` by one or more cycles around edge L+1. A press just one cycle short, or one that just meets the limit, therefore separates the two cases at once. A bad blanking state shows only on the next rising edge of `edge_in`: a too-short window lets a reset through at offset `DEBOUNCE_TICKS`, and a missing re-arm blocks the reset at offset `DEBOUNCE_TICKS`+1. A timer that does not reload ends the pulse early. That is visible some cycles after the second trigger, at the point where the first pulse would have ended.

// File: rtl/pbrst_pkg.sv
package pbrst_pkg;

   // Three-level setup time code; both upper codes select the longest time.
   typedef enum logic [1:0] {
      HSEL_SHORT    = 2'b00,
      HSEL_MID      = 2'b01,
      HSEL_LONG     = 2'b10,
      HSEL_LONG_ALT = 2'b11
   } hsel_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   function automatic int unsigned cwidth(input int unsigned maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction

endpackage

// File: rtl/pbrst_sync.sv
module pbrst_sync #(
   parameter int unsigned WIDTH = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         logic meta_q;
         logic stab_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               meta_q <= RST_VAL[b];
               stab_q <= RST_VAL[b];
            end else begin
               meta_q <= d[b];
               stab_q <= meta_q;
            end
         end
         assign q[b] = stab_q;
      end
   endgenerate

endmodule

// File: rtl/pbrst_tick.sv
module pbrst_tick #(
   parameter int unsigned DIV = 1000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);

   localparam int unsigned TW = pbrst_pkg::cwidth(DIV - 1);

   logic [TW-1:0] div_q;

   generate
      if (DIV < 1) begin : g_bad_div
         $error("pbrst_tick: DIV must be at least 1");
      end
   endgenerate

   assign tick = (div_q == TW'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    div_q <= '0;
      else if (tick) div_q <= '0;
      else           div_q <= div_q + TW'(1);
   end

endmodule

// File: rtl/pbrst_hold.sv
module pbrst_hold #(
   parameter int unsigned SHORT_TICKS = 2000,
   parameter int unsigned MID_TICKS   = 6000,
   parameter int unsigned LONG_TICKS  = 10000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       press_n,
   input  logic [1:0] sel,
   output logic       req
);
   import pbrst_pkg::*;

   localparam int unsigned LMAX = max3(SHORT_TICKS, MID_TICKS, LONG_TICKS);
   localparam int unsigned CW   = cwidth(LMAX);

   generate
      if (SHORT_TICKS < 2 || MID_TICKS < 2 || LONG_TICKS < 2) begin : g_bad_len
         $error("pbrst_hold: every setup time must be at least 2 ticks");
      end
   endgenerate

   logic          pressed;
   logic          fired;
   logic          at_limit;
   logic [CW-1:0] cnt;
   logic [CW-1:0] limit;

   assign pressed = ~press_n;

   always_comb begin
      case (hsel_e'(sel))
         HSEL_SHORT: limit = CW'(SHORT_TICKS);
         HSEL_MID:   limit = CW'(MID_TICKS);
         default:    limit = CW'(LONG_TICKS);
      endcase
   end

   // >= keeps a select change during a closure from stalling the count
   assign at_limit = (cnt >= limit - CW'(1));
   assign req      = pressed && tick && !fired && at_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         fired <= 1'b0;
      end else if (!pressed) begin
         cnt   <= '0;
         fired <= 1'b0;
      end else if (tick && !fired) begin
         if (at_limit) begin
            fired <= 1'b1;
            cnt   <= '0;
         end else begin
            cnt <= cnt + CW'(1);
         end
      end
   end

   assert_press_precedes_fire_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> $past(pressed));

   assert_single_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req) |-> !req);

endmodule

// File: rtl/pbrst_edge.sv
module pbrst_edge #(
   parameter int unsigned DEB_TICKS = 240
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic lvl,
   output logic req
);
   import pbrst_pkg::*;

   localparam int unsigned DW = cwidth(DEB_TICKS);

   generate
      if (DEB_TICKS < 1) begin : g_bad_deb
         $error("pbrst_edge: blanking window must be at least 1 tick");
      end
   endgenerate

   logic          lvl_q;
   logic          armed;
   logic          rise;
   logic          fall;
   logic [DW-1:0] dcnt;

   assign rise = lvl & ~lvl_q;
   assign fall = ~lvl & lvl_q;
   assign req  = rise && (dcnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         armed <= 1'b0;
         dcnt  <= '0;
      end else begin
         lvl_q <= lvl;
         if (fall && armed)            dcnt <= DW'(DEB_TICKS);
         else if (dcnt != '0 && tick)  dcnt <= dcnt - DW'(1);
         if (req)       armed <= 1'b1;
         else if (fall) armed <= 1'b0;
      end
   end

   assert_window_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && armed) |=> (dcnt == DW'(DEB_TICKS)));

   assert_window_drains_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!(fall && armed) && dcnt != '0 && tick) |=> (dcnt == $past(dcnt) - DW'(1)));

   assert_ignored_rise_no_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && dcnt != '0 && !armed) |=> !armed);

endmodule

// File: rtl/pbrst_pulse.sv
module pbrst_pulse #(
   parameter int unsigned TICKS = 140
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic start,
   output logic active
);
   import pbrst_pkg::*;

   localparam int unsigned PW = cwidth(TICKS);

   generate
      if (TICKS < 1) begin : g_bad_len
         $error("pbrst_pulse: pulse must be at least 1 tick");
      end
   endgenerate

   logic [PW-1:0] cnt;

   assign active = (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (start)               cnt <= PW'(TICKS);
      else if (cnt != '0 && tick)   cnt <= cnt - PW'(1);
   end

   assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt == PW'(TICKS)));

   assert_countdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && cnt != '0 && tick) |=> (cnt == $past(cnt) - PW'(1)));

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !tick) |=> $stable(cnt));

endmodule

// File: rtl/pbrst_ctrl.sv
module pbrst_ctrl #(
   parameter int unsigned TICK_DIV          = 1000,
   parameter int unsigned HOLD_SHORT_TICKS  = 2000,
   parameter int unsigned HOLD_MID_TICKS    = 6000,
   parameter int unsigned HOLD_LONG_TICKS   = 10000,
   parameter int unsigned DEBOUNCE_TICKS    = 240,
   parameter int unsigned PULSE_SHORT_TICKS = 140,
   parameter int unsigned PULSE_LONG_TICKS  = 240,
   parameter bit          PULSE_USE_LONG    = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold_n,
   input  logic       edge_in,
   input  logic [1:0] hold_sel,
   output logic       rst_drive
);

   logic       tick;
   logic [1:0] sync_q;
   logic       hold_req;
   logic       edge_req;
   logic       any_req;

   pbrst_tick #(.DIV(TICK_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   // bit 0: long-press line (idle high), bit 1: edge line (idle low)
   pbrst_sync #(.WIDTH(2), .RST_VAL(2'b01)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({edge_in, hold_n}),
      .q    (sync_q)
   );

   pbrst_hold #(
      .SHORT_TICKS(HOLD_SHORT_TICKS),
      .MID_TICKS  (HOLD_MID_TICKS),
      .LONG_TICKS (HOLD_LONG_TICKS)
   ) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .press_n(sync_q[0]),
      .sel    (hold_sel),
      .req    (hold_req)
   );

   pbrst_edge #(.DEB_TICKS(DEBOUNCE_TICKS)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .lvl  (sync_q[1]),
      .req  (edge_req)
   );

   assign any_req = hold_req | edge_req;

   generate
      if (PULSE_USE_LONG) begin : g_pulse_long
         pbrst_pulse #(.TICKS(PULSE_LONG_TICKS)) u_pulse (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .start (any_req),
            .active(rst_drive)
         );
      end else begin : g_pulse_short
         pbrst_pulse #(.TICKS(PULSE_SHORT_TICKS)) u_pulse (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .start (any_req),
            .active(rst_drive)
         );
      end
   endgenerate

   assert_trigger_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
      any_req |=> rst_drive);

   assert_reset_quiet_R9: assert property (@(posedge clk)
      !rst_n |-> !rst_drive);

endmodule

// File: tb/pbrst_ctrl_bench.sv
module pbrst_ctrl_bench;

   localparam int HS  = 20;
   localparam int HM  = 40;
   localparam int HL  = 60;
   localparam int DEB = 30;
   localparam int P   = 16;
   localparam int NV  = 8;

   // {sel[12:11], press length[10:1], expected pulse[0]}
   localparam logic [12:0] VEC [NV] = '{
      {2'b00, 10'd20, 1'b1}, {2'b00, 10'd19, 1'b0},
      {2'b01, 10'd40, 1'b1}, {2'b01, 10'd39, 1'b0},
      {2'b10, 10'd60, 1'b1}, {2'b11, 10'd60, 1'b1},
      {2'b10, 10'd59, 1'b0}, {2'b00, 10'd5,  1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hold_n = 1'b1;
   logic       edge_in = 1'b0;
   logic [1:0] hold_sel = 2'b00;
   logic       rst_drive;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   pbrst_ctrl #(
      .TICK_DIV(1), .HOLD_SHORT_TICKS(HS), .HOLD_MID_TICKS(HM),
      .HOLD_LONG_TICKS(HL), .DEBOUNCE_TICKS(DEB),
      .PULSE_SHORT_TICKS(P), .PULSE_LONG_TICKS(25), .PULSE_USE_LONG(1'b0)
   ) u_pbrst_ctrl (
      .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .edge_in(edge_in),
      .hold_sel(hold_sel), .rst_drive(rst_drive)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: rst_drive=%0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int lim(input logic [1:0] s);
      return (s == 2'b00) ? HS : (s == 2'b01) ? HM : HL;
   endfunction

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run state=hung expected=complete");
         summary();
         $finish;
      end
   end

   initial begin
      // R9: quiet in and after power-on reset
      idle(3);
      chk("R9 during reset", rst_drive, 1'b0);
      rst_n = 1'b1;
      idle(5);
      chk("R9 after reset", rst_drive, 1'b0);

      // R1 / R2: vector walk over select codes and press lengths
      for (int v = 0; v < NV; v++) begin
         logic [1:0] s;
         int len;
         int L;
         logic ex;
         s   = VEC[v][12:11];
         len = int'(VEC[v][10:1]);
         ex  = VEC[v][0];
         L   = lim(s);
         hold_sel = s;
         idle(2);
         hold_n = 1'b0;
         for (int i = 1; i <= L + 2; i++) begin
            @(negedge clk);
            if (i == len) hold_n = 1'b1;
            if (i == L + 1) chk(ex ? "R1 early" : "R2 early", rst_drive, 1'b0);
            if (i == L + 2) chk(ex ? "R1" : "R2", rst_drive, ex);
         end
         hold_n = 1'b1;
         idle(P + 6);
         chk("R7 pulse over", rst_drive, 1'b0);
      end

      // R4 / R7: instant edge reset and pulse width
      edge_in = 1'b1;
      for (int i = 1; i <= P + 3; i++) begin
         @(negedge clk);
         if (i == 2) chk("R4 sync latency", rst_drive, 1'b0);
         if (i == 3) chk("R4", rst_drive, 1'b1);
         if (i == P + 2) chk("R7 last high", rst_drive, 1'b1);
         if (i == P + 3) chk("R7 end", rst_drive, 1'b0);
      end
      idle(2);
      // R5: rise exactly DEB after the accepted fall is ignored
      edge_in = 1'b0;
      idle(DEB);
      edge_in = 1'b1;
      for (int i = 1; i <= 6; i++) begin
         @(negedge clk);
         if (i == 3 || i == 6) chk("R5 blanked rise", rst_drive, 1'b0);
      end
      // R5: fall of the ignored phase must not reopen the window
      edge_in = 1'b0;
      idle(3);
      edge_in = 1'b1;
      idle(3);
      chk("R5 no reopen", rst_drive, 1'b1);
      idle(P + 4);
      // R6: rise at DEB+1 after the accepted fall is taken
      edge_in = 1'b0;
      idle(DEB + 1);
      edge_in = 1'b1;
      idle(2);
      chk("R6 latency", rst_drive, 1'b0);
      idle(1);
      chk("R6", rst_drive, 1'b1);
      idle(P + 4);
      edge_in = 1'b0;
      idle(DEB + 6);

      // R3: one long closure gives one pulse
      hold_sel = 2'b00;
      idle(2);
      hold_n = 1'b0;
      for (int i = 1; i <= HS + P + 20; i++) begin
         @(negedge clk);
         if (i == HS + 2)      chk("R3 fire", rst_drive, 1'b1);
         if (i == HS + P + 1)  chk("R3 last high", rst_drive, 1'b1);
         if (i == HS + P + 2)  chk("R3 end", rst_drive, 1'b0);
         if (i == HS + P + 19) chk("R3 no refire", rst_drive, 1'b0);
      end
      hold_n = 1'b1;
      idle(5);

      // R8: edge trigger during a long-press pulse reloads the timer
      hold_n = 1'b0;
      for (int i = 1; i <= 52; i++) begin
         @(negedge clk);
         if (i == 25) hold_n = 1'b1;
         if (i == 30) edge_in = 1'b1;
         if (i == 22) chk("R8 hold pulse", rst_drive, 1'b1);
         if (i == 40) chk("R8 extended", rst_drive, 1'b1);
         if (i == 48) chk("R8 last high", rst_drive, 1'b1);
         if (i == 49) chk("R8 end", rst_drive, 1'b0);
      end
      edge_in = 1'b0;
      idle(DEB + P + 5);
      chk("R9 idle at end", rst_drive, 1'b0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule